// File: doc/BRIEF.md
# Interrupt Event Register with Write-One Set and Clear

This block keeps the 32-bit interrupt event vector of a bus-mastering host controller, along with the mask that goes with it. Hardware sources, such as generic event lines, per-context fatal errors, a cycle-overrun line and a group of tardy-acknowledge conditions, latch event bits on their rising edges. Software sets bits with a write-one operation at one address and clears them with a write-one operation at another. The mask has its own set and clear addresses that work the same way.

A read of the event register returns the event bits ANDed with the mask. The level output `irq` is high whenever that masked vector is non-zero.

Some events have side effects. A fatal error on a DMA context raises the unrecoverable-error bit and blocks that context's own hardware interrupts while the bit stays set. A cycle-overrun event seen while the node acts as cycle master raises a pulse that tells the owner of the cycle-master control bit to drop it. The register bus is a plain address, write strobe and data interface with combinational read data, and it has no handshake. Every write completes in one cycle.

Top module: `irq_event_regs`

## Requirements
- R1: Bit b of `src_evt` sets event bit b on the cycle after it rises, for b in 0..23 and b = 26; a source held high sets its bit once only, so after a clear the bit stays 0 while the source stays high. Bits 24, 25 and 27..31 of `src_evt` have no effect.
- R2: A write to address 0x80 sets each event bit whose write-data bit is 1; bits written 0 keep their value.
- R3: An event bit goes to 0 only through a write of 1 to that bit at address 0x84.
- R4: A read at 0x80 or 0x84 returns event AND mask. Writes of 1 at 0x88 set mask bits, writes of 1 at 0x8C clear them, and a read at 0x88 or 0x8C returns the mask. Any other address reads 0.
- R5: Event bits 31, 30 and 28 always read 0; set writes and hardware sources cannot change them.
- R6: Event bit 29 is software-only: set at 0x80, cleared at 0x84, and never set by any input.
- R7: A rising edge on `ctx_fatal[c]` sets event bit 24 and marks context c, which owns event bit c (c < NUM_CTX). While bit 24 is 1, edges on `src_evt[c]` of a marked context do not set bit c. After bit 24 is cleared the mark is dropped.
- R8: A rising edge of `cyc_long` while `cyc_master` is 1 sets event bit 25 and drives `cyc_master_clr` high in the same cycle that the edge appears. While `cyc_master` is 0, the edge sets nothing and raises no pulse.
- R9: Event bit 27 is set by a rising edge of (`tardy_en` AND any bit of `tardy_cond`); tardy conditions with `tardy_en` low set nothing.
- R10: `irq` is 1 exactly when some bit is 1 in both the event and the mask registers, visible the cycle after the write or edge that changes them.
- R11: A hardware edge and a clear write to the same bit in the same cycle leave the bit at 1.
- R12: After reset all event and mask bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_evt | input | 32 | Generic hardware event lines, edge sensitive |
| ctx_fatal | input | NUM_CTX | Per-context fatal error lines, edge sensitive |
| cyc_long | input | 1 | Cycle overrun line, edge sensitive |
| cyc_master | input | 1 | Current value of the cycle-master control bit |
| tardy_en | input | 1 | Enable for the tardy-acknowledge event |
| tardy_cond | input | 3 | Tardy or busy conditions |
| cyc_master_clr | output | 1 | Pulse requesting that the cycle-master bit be cleared |
| irq | output | 1 | Level interrupt, any masked event pending |

## Verification
The assertions assume that every edge-sensitive input is low when reset is released, so the first event they see is a true edge. They also assume that `bus_wr` is driven to a known value on every cycle after reset. The bench drives every source and bus pin low before it releases reset. It changes inputs only on falling clock edges, so each rising edge the design sees was meant as one. Every scenario returns its sources to 0 and clears the bits it raised before the next scenario starts, so no edge or leftover state carries from one test into the next.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int REG_W   = 32;
  localparam int TARDY_N = 3;

  localparam logic [7:0] OFS_EVT_SET = 8'h80;
  localparam logic [7:0] OFS_EVT_CLR = 8'h84;
  localparam logic [7:0] OFS_MSK_SET = 8'h88;
  localparam logic [7:0] OFS_MSK_CLR = 8'h8C;

  localparam int BIT_FATAL = 24;
  localparam int BIT_CYC   = 25;
  localparam int BIT_TARDY = 27;
  localparam int BIT_SOFT  = 29;

  // bits that can hold a value in the event register (31, 30, 28 stay 0)
  localparam logic [REG_W-1:0] EVT_KEEP    = 32'h2FFF_FFFF;
  // bits driven directly by the generic source vector
  localparam logic [REG_W-1:0] GENERIC_SRC = 32'h04FF_FFFF;
  localparam logic [REG_W-1:0] RSVD_BITS   = 32'hD000_0000;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R1: an edge is reported for one cycle only, even if the level stays high
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_wsc_reg.sv
module irq_wsc_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] hw_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // a set, from software or hardware, outranks a clear in the same cycle
  always_comb q_d = ((q_o & ~clr_i) | set_i | hw_i) & KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  // R2: a bit written 1 at the set address reads 1 afterwards
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_i) & KEEP & ~q_o) == '0));

  // R3: a bit only drops after a clear write that named it
  assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(q_o) & ~q_o & ~$past(clr_i)) == '0));

  // R11: a hardware set survives a simultaneous clear
  assert_hw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(hw_i) & KEEP) & ~q_o) == '0));
endmodule

// File: rtl/irq_src_merge.sv
module irq_src_merge
  import irq_evt_pkg::*;
#(
  parameter int NUM_CTX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_W-1:0]   src_evt_i,
  input  logic [NUM_CTX-1:0] ctx_fatal_i,
  input  logic               cyc_long_i,
  input  logic               cyc_master_i,
  input  logic               tardy_en_i,
  input  logic [TARDY_N-1:0] tardy_cond_i,
  input  logic               fatal_bit_i,
  output logic [REG_W-1:0]   hw_set_o,
  output logic [NUM_CTX-1:0] dead_o,
  output logic               cyc_clr_o
);
  logic [REG_W-1:0]   gen_rise;
  logic [NUM_CTX-1:0] fatal_rise;
  logic               cyc_rise;
  logic               tardy_rise;
  logic               tardy_lvl;
  logic [REG_W-1:0]   gen_gated;
  logic [NUM_CTX-1:0] dead_q;

  assign tardy_lvl = tardy_en_i & (|tardy_cond_i);

  irq_edge_det #(.W(REG_W)) u_gen_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(src_evt_i), .rise_o(gen_rise));
  irq_edge_det #(.W(NUM_CTX)) u_fatal_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ctx_fatal_i), .rise_o(fatal_rise));
  irq_edge_det #(.W(1)) u_cyc_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(cyc_long_i), .rise_o(cyc_rise));
  irq_edge_det #(.W(1)) u_tardy_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(tardy_lvl), .rise_o(tardy_rise));

  // contexts marked dead keep their mark while the fatal bit is up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              dead_q <= '0;
    else if (!fatal_bit_i && fatal_rise == '0) dead_q <= '0;
    else                                     dead_q <= dead_q | fatal_rise;
  end
  assign dead_o = dead_q;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b < NUM_CTX) begin : g_ctx
      assign gen_gated[b] = gen_rise[b] & GENERIC_SRC[b] & ~(fatal_bit_i & dead_q[b]);
    end else begin : g_plain
      assign gen_gated[b] = gen_rise[b] & GENERIC_SRC[b];
    end
  end

  assign cyc_clr_o = cyc_rise & cyc_master_i;

  always_comb begin
    hw_set_o            = gen_gated;
    hw_set_o[BIT_FATAL] = |fatal_rise;
    hw_set_o[BIT_CYC]   = cyc_clr_o;
    hw_set_o[BIT_TARDY] = tardy_rise;
  end

  // R8: the clear request needs the cycle-master bit to be on
  assert_cyc_needs_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_clr_o |-> cyc_master_i);

  // R9: the tardy bit is only requested while its enable is high
  assert_tardy_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_o[BIT_TARDY] |-> tardy_en_i);
endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CTX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [REG_W-1:0]    src_evt,
  input  logic [NUM_CTX-1:0]  ctx_fatal,
  input  logic                cyc_long,
  input  logic                cyc_master,
  input  logic                tardy_en,
  input  logic [TARDY_N-1:0]  tardy_cond,
  output logic                cyc_master_clr,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] A_EVT_SET = ADDR_W'(OFS_EVT_SET);
  localparam logic [ADDR_W-1:0] A_EVT_CLR = ADDR_W'(OFS_EVT_CLR);
  localparam logic [ADDR_W-1:0] A_MSK_SET = ADDR_W'(OFS_MSK_SET);
  localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(OFS_MSK_CLR);

  logic [REG_W-1:0]   evt_set, evt_clr, msk_set, msk_clr;
  logic [REG_W-1:0]   evt_q, msk_q, hw_set, pend;
  logic [NUM_CTX-1:0] dead;

  always_comb begin
    evt_set = '0;
    evt_clr = '0;
    msk_set = '0;
    msk_clr = '0;
    if (bus_wr) begin
      unique case (bus_addr)
        A_EVT_SET: evt_set = bus_wdata;
        A_EVT_CLR: evt_clr = bus_wdata;
        A_MSK_SET: msk_set = bus_wdata;
        A_MSK_CLR: msk_clr = bus_wdata;
        default: ;
      endcase
    end
  end

  irq_src_merge #(.NUM_CTX(NUM_CTX)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .src_evt_i(src_evt), .ctx_fatal_i(ctx_fatal),
    .cyc_long_i(cyc_long), .cyc_master_i(cyc_master),
    .tardy_en_i(tardy_en), .tardy_cond_i(tardy_cond),
    .fatal_bit_i(evt_q[BIT_FATAL]),
    .hw_set_o(hw_set), .dead_o(dead), .cyc_clr_o(cyc_master_clr));

  irq_wsc_reg #(.W(REG_W), .KEEP(EVT_KEEP)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .set_i(evt_set), .clr_i(evt_clr), .hw_i(hw_set), .q_o(evt_q));

  irq_wsc_reg #(.W(REG_W), .KEEP({REG_W{1'b1}})) u_msk (
    .clk(clk), .rst_n(rst_n),
    .set_i(msk_set), .clr_i(msk_clr), .hw_i({REG_W{1'b0}}), .q_o(msk_q));

  assign pend = evt_q & msk_q;
  assign irq  = |pend;

  always_comb begin
    if (bus_addr == A_EVT_SET || bus_addr == A_EVT_CLR)      bus_rdata = pend;
    else if (bus_addr == A_MSK_SET || bus_addr == A_MSK_CLR) bus_rdata = msk_q;
    else                                                     bus_rdata = '0;
  end

  // R5: reserved event positions never show up in an event read
  assert_rsvd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_EVT_SET) |-> ((bus_rdata & RSVD_BITS) == '0));

  // R6: the software bit only rises after a set write naming it
  assert_soft_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[BIT_SOFT]) |-> $past(evt_set[BIT_SOFT]));

  // R7: a marked context's bit cannot rise from hardware while the fatal bit holds
  assert_ctx_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q[NUM_CTX-1:0] & ~$past(evt_q[NUM_CTX-1:0]) & ~$past(evt_set[NUM_CTX-1:0])
      & $past(dead) & {NUM_CTX{$past(evt_q[BIT_FATAL])}}) == '0));

  // R8: the clear request is always accompanied by the overrun event
  assert_cyc_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_master_clr |=> evt_q[BIT_CYC]);

  // R9: the tardy bit rises only from software or with the enable up
  assert_tardy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[BIT_TARDY]) |-> ($past(tardy_en) || $past(evt_set[BIT_TARDY])));

  // R10: an interrupt needs at least one enabled mask bit
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk_q != '0));
endmodule

// File: tb/irq_event_regs_tb_top.sv
module irq_event_regs_tb_top;
  localparam int NCTX = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src_evt;
  logic [NCTX-1:0] ctx_fatal;
  logic        cyc_long, cyc_master, tardy_en;
  logic [2:0]  tardy_cond;
  logic        cyc_master_clr, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_event_regs #(.ADDR_W(8), .NUM_CTX(NCTX)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .ctx_fatal(ctx_fatal), .cyc_long(cyc_long), .cyc_master(cyc_master),
    .tardy_en(tardy_en), .tardy_cond(tardy_cond),
    .cyc_master_clr(cyc_master_clr), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h80, v); check("R12 event after reset", v, 32'h0);
    rd(8'h88, v); check("R12 mask after reset", v, 32'h0);
    check("R12 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sw_set_clear;
    logic [31:0] v;
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h8C, v); check("R4 mask readback", v, 32'hFFFF_FFFF);
    wr(8'h80, 32'h0000_0A05);
    rd(8'h80, v); check("R2 set write", v, 32'h0000_0A05);
    wr(8'h80, 32'h0000_0000);
    rd(8'h80, v); check("R2 zero write no effect", v, 32'h0000_0A05);
    wr(8'h84, 32'h0000_0001);
    rd(8'h84, v); check("R3 clear one bit", v, 32'h0000_0A04);
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R3 other address no clear", v, 32'h0000_0A04);
    rd(8'h90, v); check("R4 unmapped reads zero", v, 32'h0);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R3 clear all", v, 32'h0);
  endtask

  task automatic t_mask_read;
    logic [31:0] v;
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'h80, 32'h0000_0018);
    rd(8'h80, v); check("R4 fully masked read", v, 32'h0);
    check("R10 irq low with mask 0", {31'b0, irq}, 32'h0);
    wr(8'h88, 32'h0000_0008);
    rd(8'h80, v); check("R4 partial mask read", v, 32'h0000_0008);
    check("R10 irq high", {31'b0, irq}, 32'h1);
    wr(8'h84, 32'h0000_0008);
    check("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R4 unmask shows bit 4", v, 32'h0000_0010);
    wr(8'h84, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    @(negedge clk); src_evt[5] = 1'b1; src_evt[26] = 1'b1;
    idle(1);
    rd(8'h80, v); check("R1 edge sets bits 5 and 26", v, 32'h0400_0020);
    wr(8'h84, 32'h0400_0020);
    idle(3);
    rd(8'h80, v); check("R1 held level does not re-set", v, 32'h0);
    @(negedge clk); src_evt = 32'hFB00_0000;
    idle(2);
    rd(8'h80, v); check("R1 R5 R6 unused source bits ignored", v, 32'h0);
    src_evt = '0;
    idle(1);
  endtask

  task automatic t_reserved_soft;
    logic [31:0] v;
    wr(8'h80, 32'hF000_0000);
    rd(8'h80, v); check("R5 R6 only bit 29 sets", v, 32'h2000_0000);
    wr(8'h84, 32'h2000_0000);
    rd(8'h80, v); check("R6 soft bit cleared", v, 32'h0);
  endtask

  task automatic t_fatal;
    logic [31:0] v;
    @(negedge clk); ctx_fatal[2] = 1'b1;
    idle(1);
    rd(8'h80, v); check("R7 fatal sets bit 24", v, 32'h0100_0000);
    @(negedge clk); src_evt[2] = 1'b1; src_evt[3] = 1'b1;
    idle(1);
    rd(8'h80, v); check("R7 dead context blocked", v, 32'h0100_0008);
    @(negedge clk); src_evt = '0; ctx_fatal = '0;
    wr(8'h84, 32'hFFFF_FFFF);
    idle(2);
    @(negedge clk); src_evt[2] = 1'b1;
    idle(1);
    rd(8'h80, v); check("R7 unblocked after clear", v, 32'h0000_0004);
    src_evt = '0;
    wr(8'h84, 32'hFFFF_FFFF);
  endtask

  task automatic t_cycle;
    logic [31:0] v;
    @(negedge clk); cyc_master = 1'b1; cyc_long = 1'b1;
    #1 check("R8 clear pulse same cycle", {31'b0, cyc_master_clr}, 32'h1);
    @(negedge clk);
    check("R8 pulse is one cycle", {31'b0, cyc_master_clr}, 32'h0);
    rd(8'h80, v); check("R8 bit 25 set", v, 32'h0200_0000);
    @(negedge clk); cyc_long = 1'b0; cyc_master = 1'b0;
    wr(8'h84, 32'hFFFF_FFFF);
    @(negedge clk); cyc_long = 1'b1;
    #1 check("R8 no pulse when not master", {31'b0, cyc_master_clr}, 32'h0);
    idle(1);
    rd(8'h80, v); check("R8 no bit 25 when not master", v, 32'h0);
    cyc_long = 1'b0;
  endtask

  task automatic t_tardy;
    logic [31:0] v;
    @(negedge clk); tardy_cond = 3'b010;
    idle(2);
    rd(8'h80, v); check("R9 disabled tardy", v, 32'h0);
    @(negedge clk); tardy_cond = 3'b000; tardy_en = 1'b1;
    @(negedge clk); tardy_cond = 3'b100;
    idle(1);
    rd(8'h80, v); check("R9 enabled tardy sets bit 27", v, 32'h0800_0000);
    tardy_cond = '0; tardy_en = 1'b0;
    wr(8'h84, 32'hFFFF_FFFF);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(8'h80, 32'h0000_0040);
    @(negedge clk);
    src_evt[6] = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h0000_0040; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd(8'h80, v); check("R11 edge beats clear", v, 32'h0000_0040);
    src_evt = '0;
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R11 later clear works", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=%0d exp=%0d", n_chk, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    src_evt = '0; ctx_fatal = '0; cyc_long = 1'b0; cyc_master = 1'b0;
    tardy_en = 1'b0; tardy_cond = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sw_set_clear();
    t_mask_read();
    t_edges();
    t_reserved_soft();
    t_fatal();
    t_cycle();
    t_tardy();
    t_priority();
    idle(2);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule